// File: doc/BRIEF.md
# Card Clock Gate with Power-of-Two Divider

This block produces the clock that drives an MMC/SD card. It works from the block clock and applies a divider set by a 3-bit exponent N. The card clock stays high for 2^N block-clock cycles and then low for 2^N cycles. The base rate is half the block-clock rate, so the card clock runs at the base rate divided by 2^N, and N = 0 gives the base rate itself. Software controls the clock with a write strobe that carries a 2-bit command code. A second strobe loads the divide exponent. A third strobe clears the sticky clock-off flag.

A start command takes effect at once, and the first period begins with a full high half. A stop command never cuts a half-period short. The clock keeps running until the low half of the current period is complete. At the edge where the clock would rise, it stays low instead. In that same cycle the running status clears and a one-cycle clock-off event fires. The event is also held in a sticky flag. Software polls the running status until it reads 0, and only then reprograms the exponent for the next start.

Top module: `sdclk_gate`

## Requirements
- R1: After reset the card clock, running status, clock-off event and clock-off flag are all 0, and the stored exponent is 0.
- R2: A command write with code 2 (start) while stopped makes the card clock 1 and running 1 in the next cycle. From then on the clock repeats 2^N cycles high followed by 2^N cycles low, where N is the stored exponent.
- R3: An exponent write stores its value at any time, but a running clock keeps the exponent it was started with. A stored value is used only from the next start.
- R4: A command write with code 1 (stop) while running lets the clock finish the low half of the current period. In the cycle where it would next go high, it stays low and running reads 0. No high or low half is ever shortened.
- R5: At the moment the clock stops, the clock-off event is 1 for exactly one cycle and the sticky flag becomes 1 in that same cycle. The flag stays 1 until it is cleared.
- R6: A clear write makes the flag 0 in the next cycle. If the clear falls in the same cycle as a stop taking effect, the flag ends up 1.
- R7: A stop command while stopped, and the command codes 0 and 3, change nothing. No event fires and the clock stays low.
- R8: A start command while running leaves the clock phase unchanged and cancels any stop still waiting for its safe point.
- R9: Whenever running reads 0, the card clock is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the base rate |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Command register write strobe |
| ctl_code | input | 2 | Command code: 1 stop, 2 start, others no action |
| div_wr | input | 1 | Exponent register write strobe |
| div_exp | input | EXP_W | Divide exponent N |
| off_clr | input | 1 | Write strobe that clears the clock-off flag |
| card_clk | output | 1 | Gated, divided card clock |
| clk_running | output | 1 | 1 while the card clock is enabled |
| clk_off_pulse | output | 1 | One-cycle event when the clock stops |
| clk_off_flag | output | 1 | Sticky clock-off flag |

## Verification
Two actions can land in the same cycle. One is a stop reaching its safe point, which sets the flag. The other is a software clear, which resets it. The bench predicts the cycle in which a pending stop will take effect and drives the clear write in exactly that cycle. It then expects the flag to read 1 afterwards and only a later clear to drop it. A second collision places a start command in the cycle right after a stop command. In that case the clock must keep its phase through what would have been the stopping edge.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  typedef enum logic [1:0] {
    CC_NOP   = 2'd0,
    CC_STOP  = 2'd1,
    CC_START = 2'd2,
    CC_RSVD  = 2'd3
  } ccg_cmd_e;
endpackage

// File: rtl/sdclk_divider.sv
module sdclk_divider #(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             launch_i,
  input  logic             halt_i,
  input  logic             div_wr,
  input  logic [EXP_W-1:0] div_exp,
  output logic             card_clk,
  output logic             safe_o
);
  localparam int CNT_W = (1 << EXP_W) - 1;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [EXP_W-1:0] exp_pend, exp_act;
  logic [CNT_W-1:0] cnt, half_m1;

  // half-period length minus one; wraps correctly at the largest exponent
  always_comb half_m1 = (ONE << exp_act) - ONE;

  // end of a low half: the only point where gating may close
  always_comb safe_o = !card_clk && (cnt == half_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_pend <= '0;
      exp_act  <= '0;
    end else begin
      if (div_wr) exp_pend <= div_exp;
      if (launch_i) exp_act <= div_wr ? div_exp : exp_pend;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      card_clk <= 1'b0;
    end else if (launch_i) begin
      cnt      <= '0;
      card_clk <= 1'b1;
    end else if (halt_i || !run_i) begin
      cnt      <= '0;
      card_clk <= 1'b0;
    end else if (cnt == half_m1) begin
      cnt      <= '0;
      card_clk <= ~card_clk;
    end else begin
      cnt      <= cnt + ONE;
    end
  end

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !run_i |-> !card_clk); // R9
  AST_START_HIGH: assert property (@(posedge clk) disable iff (rst)
    $rose(run_i) |-> card_clk); // R2
  AST_STOP_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(run_i) |-> !card_clk && !$past(card_clk)); // R4
endmodule

// File: rtl/sdclk_gate_ctrl.sv
module sdclk_gate_ctrl
  import sdclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_wr,
  input  logic [1:0] ctl_code,
  input  logic       off_clr,
  input  logic       safe_i,
  output logic       launch_o,
  output logic       halt_o,
  output logic       running,
  output logic       off_evt,
  output logic       off_flag
);
  logic start_cmd, stop_cmd, stop_pend;

  always_comb begin
    start_cmd = ctl_wr && (ctl_code == CC_START);
    stop_cmd  = ctl_wr && (ctl_code == CC_STOP);
    launch_o  = start_cmd && !running;
    halt_o    = running && safe_i && (stop_cmd || (stop_pend && !start_cmd));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running   <= 1'b0;
      stop_pend <= 1'b0;
      off_evt   <= 1'b0;
      off_flag  <= 1'b0;
    end else begin
      if (launch_o)    running <= 1'b1;
      else if (halt_o) running <= 1'b0;

      if (halt_o || !running || start_cmd) stop_pend <= 1'b0;
      else if (stop_cmd)                   stop_pend <= 1'b1;

      off_evt  <= halt_o;
      off_flag <= halt_o || (off_flag && !off_clr);
    end
  end

  AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    off_evt |=> !off_evt); // R5
  AST_FLAG_WITH_EVT: assert property (@(posedge clk) disable iff (rst)
    off_evt |-> off_flag); // R5
  AST_FLAG_CLR_ONLY: assert property (@(posedge clk) disable iff (rst)
    $fell(off_flag) |-> $past(off_clr)); // R6
  AST_EVT_ON_STOP: assert property (@(posedge clk) disable iff (rst)
    $fell(running) |-> off_evt); // R5
endmodule

// File: rtl/sdclk_gate.sv
module sdclk_gate #(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [1:0]       ctl_code,
  input  logic             div_wr,
  input  logic [EXP_W-1:0] div_exp,
  input  logic             off_clr,
  output logic             card_clk,
  output logic             clk_running,
  output logic             clk_off_pulse,
  output logic             clk_off_flag
);
  logic safe, launch, halt;

  sdclk_gate_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ctl_wr   (ctl_wr),
    .ctl_code (ctl_code),
    .off_clr  (off_clr),
    .safe_i   (safe),
    .launch_o (launch),
    .halt_o   (halt),
    .running  (clk_running),
    .off_evt  (clk_off_pulse),
    .off_flag (clk_off_flag)
  );

  sdclk_divider #(.EXP_W(EXP_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .run_i    (clk_running),
    .launch_i (launch),
    .halt_i   (halt),
    .div_wr   (div_wr),
    .div_exp  (div_exp),
    .card_clk (card_clk),
    .safe_o   (safe)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !card_clk && !clk_running && !clk_off_flag); // R1
endmodule

// File: tb/sdclk_gate_test.sv
module sdclk_gate_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_wr = 1'b0;
  logic [1:0] ctl_code = 2'd0;
  logic       div_wr = 1'b0;
  logic [2:0] div_exp = 3'd0;
  logic       off_clr = 1'b0;
  logic       card_clk, clk_running, clk_off_pulse, clk_off_flag;

  always #5 clk = ~clk;

  sdclk_gate #(.EXP_W(3)) uut (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_code(ctl_code),
    .div_wr(div_wr), .div_exp(div_exp), .off_clr(off_clr),
    .card_clk(card_clk), .clk_running(clk_running),
    .clk_off_pulse(clk_off_pulse), .clk_off_flag(clk_off_flag)
  );

  typedef struct {
    logic  c, r, e, f;
    string tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, failures = 0;
  bit done = 0;

  // expectation state derived from the requirements
  bit e_run = 0, e_armed = 0, e_flag = 0;
  int pos = 0, H = 1, pexp = 0;

  function automatic bit will_stop();
    return e_run && e_armed && (((pos + 1) % (2 * H)) == 0);
  endfunction

  task automatic step(input logic cw, input logic [1:0] cv, input logic dw,
                      input logic [2:0] dv, input logic clr, input string tag);
    exp_t it;
    bit stopping = 0;
    @(negedge clk);
    ctl_wr = cw; ctl_code = cv; div_wr = dw; div_exp = dv; off_clr = clr;
    if (!e_run) begin
      if (cw && cv == 2'd2) begin
        e_run = 1; e_armed = 0; pos = 0;
        H = 1 << (dw ? int'(dv) : pexp);
        it.c = 1;
      end else it.c = 0;
    end else begin
      if (cw && cv == 2'd1) e_armed = 1;
      if (cw && cv == 2'd2) e_armed = 0;
      pos++;
      if (e_armed && (pos % (2 * H)) == 0) begin
        stopping = 1; e_run = 0; e_armed = 0; it.c = 0;
      end else it.c = ((pos % (2 * H)) < H);
    end
    if (dw) pexp = int'(dv);
    if (stopping) e_flag = 1;
    else if (clr) e_flag = 0;
    it.r = e_run; it.e = stopping; it.f = e_flag; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 2'd0, 0, 3'd0, 0, tag);
  endtask

  task automatic stop_and_wait(input bit clr_at_stop, input string tag);
    step(1, 2'd1, 0, 3'd0, 0, tag);
    while (e_run) step(0, 2'd0, 0, 3'd0, clr_at_stop && will_stop(), tag);
  endtask

  // monitor: pops one expectation per cycle and compares
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        checks++;
        if (card_clk !== it.c || clk_running !== it.r ||
            clk_off_pulse !== it.e || clk_off_flag !== it.f) begin
          failures++;
          $display("FAIL %s: clk/run/evt/flag actual=%b%b%b%b expected=%b%b%b%b",
                   it.tag, card_clk, clk_running, clk_off_pulse, clk_off_flag,
                   it.c, it.r, it.e, it.f);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    idle(2, "R1");
    // stop while stopped and unused codes
    step(1, 2'd1, 0, 3'd0, 0, "R7");
    step(1, 2'd3, 0, 3'd0, 0, "R7");
    step(1, 2'd0, 0, 3'd0, 0, "R7");
    idle(2, "R7");
    // exponent 0: base rate
    step(1, 2'd2, 0, 3'd0, 0, "R2");
    idle(6, "R2");
    stop_and_wait(0, "R4");
    idle(3, "R5");
    step(0, 2'd0, 0, 3'd0, 1, "R6");
    idle(2, "R6");
    // exponent 2 programmed while stopped
    step(0, 2'd0, 1, 3'd2, 0, "R3");
    step(1, 2'd2, 0, 3'd0, 0, "R3");
    idle(5, "R3");
    step(0, 2'd0, 1, 3'd3, 0, "R3");
    idle(20, "R3");
    // start while running, then stop cancelled by start
    step(1, 2'd2, 0, 3'd0, 0, "R8");
    idle(3, "R8");
    step(1, 2'd1, 0, 3'd0, 0, "R8");
    step(1, 2'd2, 0, 3'd0, 0, "R8");
    idle(20, "R8");
    // stop with a clear in the stopping cycle
    stop_and_wait(1, "R6");
    idle(2, "R6");
    step(0, 2'd0, 0, 3'd0, 1, "R6");
    idle(2, "R9");
    // exponent 3 stored during the last run
    step(1, 2'd2, 0, 3'd0, 0, "R3");
    idle(13, "R3");
    stop_and_wait(0, "R4");
    idle(2, "R5");
    // largest exponent
    step(0, 2'd0, 1, 3'd7, 0, "R2");
    step(1, 2'd2, 0, 3'd0, 0, "R2");
    idle(300, "R2");
    stop_and_wait(0, "R4");
    idle(3, "R9");
    @(negedge clk);
    ctl_wr = 0; div_wr = 0; off_clr = 0;
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule